// File: doc/BRIEF.md
# Multi-source reset distribution controller

This block gathers the chip's reset requests and turns them into the resets that each part of the chip sees. The requests are power-on, external warm, emulation warm, software global warm, software global cold, and test reset. Its outputs are:

- a reset for the emulation and trace logic;
- a reset for the multiplexing of the emulation pins;
- a warm reset and a cold reset for each of `NUM_DOM` power domains;
- a reset-out indicator that stays high while the host processor is held in reset.

Each domain also reports whether it is powered. When a domain switches off, it gets a warm pulse of its own. When it switches on, it gets a cold pulse of its own. Each pulse lasts `PULSE_LEN` clock cycles.

Power-on reset (`por_n`, active low) acts asynchronously. It asserts every global output at once, and those outputs release in step with the clock. All other requests and the power-state inputs are asynchronous. They pass through a `SYNC_STAGES`-flop synchronizer before they take effect. The host is released `HOST_DLY` cycles after the last global request has gone away.

Top module: `rst_dist_ctrl`

## Requirements
- R1: Any of external warm, emulation warm or software warm asserts `dom_warm_rst` of every domain.
- R2: A domain whose `dom_on` bit goes from 1 (on) to 0 (off) gets a warm reset of exactly `PULSE_LEN` cycles. No other domain's resets change, and `rst_out` stays low.
- R3: Power-on reset or software cold asserts `dom_cold_rst` of every domain.
- R4: A domain whose `dom_on` bit goes from 0 to 1 gets a cold reset of exactly `PULSE_LEN` cycles, on that domain only.
- R5: `emu_trace_rst` is asserted by power-on, software cold or test reset only. Warm sources leave it low.
- R6: `emu_pin_mux_rst` is asserted by every global source except test reset. Test reset alone leaves it low.
- R7: `rst_out` is high while any global source other than test is active. It stays high until about `HOST_DLY` cycles after the last one drops.
- R8: While `por_n` is low, `dom_cold_rst`, `emu_trace_rst`, `emu_pin_mux_rst` and `rst_out` are high without any clock edge, and `dom_warm_rst` is low. They stay asserted for at least one clock after `por_n` rises.
- R9: A synchronized request reaches its outputs on the third clock edge after it is applied, and not before the second.
- R10: Warm-only sources leave `dom_cold_rst` low. Cold-only sources leave `dom_warm_rst` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| req_ext_warm | input | 1 | External warm reset request |
| req_emu_warm | input | 1 | Emulation warm reset request |
| req_sw_warm | input | 1 | Software global warm reset request |
| req_sw_cold | input | 1 | Software global cold reset request |
| req_test | input | 1 | Test reset request |
| dom_on | input | NUM_DOM | Power state per domain, 1 = on |
| emu_trace_rst | output | 1 | Reset of emulation and trace logic |
| emu_pin_mux_rst | output | 1 | Reset of emulation pin multiplexing |
| dom_warm_rst | output | NUM_DOM | Warm reset per domain |
| dom_cold_rst | output | NUM_DOM | Cold reset per domain |
| rst_out | output | 1 | High while the host is held in reset |

## Verification
A stale copy of a domain's power state shows up as a spurious pulse on that domain. A miscounting pulse counter shows up as a pulse of the wrong width. Either appears within `PULSE_LEN` plus three cycles of the `dom_on` change. A wrong source-to-output mapping appears as a wrong level on the emulation or domain outputs three edges after a request is applied. A faulty host counter moves the falling edge of `rst_out`. That edge is checked at both ends of its window, about `HOST_DLY` cycles after the request drops.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
    localparam int REQ_W = 5;

    typedef struct packed {
        logic ext_warm;
        logic emu_warm;
        logic sw_warm;
        logic sw_cold;
        logic tst;
    } req_t;
endpackage

// File: rtl/rdc_sync.sv
module rdc_sync #(
    parameter int   W       = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d_i;
        for (int k = 1; k < STAGES; k++) begin
            stg_d[k] = stg_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= {W{RST_VAL}};
        end else begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= stg_d[k];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rdc_dom.sv
module rdc_dom #(
    parameter int PULSE_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por_act_i,
    input  logic on_i,
    input  logic glob_warm_i,
    input  logic glob_cold_i,
    output logic warm_o,
    output logic cold_o
);
    localparam int CW = $clog2(PULSE_LEN + 1);
    localparam logic [CW-1:0] LEN = CW'(PULSE_LEN);

    typedef struct packed {
        logic          prev;
        logic          arm;
        logic [CW-1:0] wcnt;
        logic [CW-1:0] ccnt;
    } dom_st_t;

    dom_st_t st_d, st_q;
    logic    go_off, go_on;

    always_comb begin
        st_d      = st_q;
        st_d.prev = on_i;
        st_d.arm  = !por_act_i;
        go_off    = st_q.arm && !por_act_i &&  st_q.prev && !on_i;
        go_on     = st_q.arm && !por_act_i && !st_q.prev &&  on_i;
        if (go_off)                 st_d.wcnt = LEN;
        else if (st_q.wcnt != '0)   st_d.wcnt = st_q.wcnt - CW'(1);
        if (go_on)                  st_d.ccnt = LEN;
        else if (st_q.ccnt != '0)   st_d.ccnt = st_q.ccnt - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign warm_o = glob_warm_i || (st_q.wcnt != '0);
    assign cold_o = glob_cold_i || (st_q.ccnt != '0);

    a_r2_off_starts_warm: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.arm && !por_act_i && st_q.prev && !on_i) |=> warm_o);
    a_r4_on_starts_cold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.arm && !por_act_i && !st_q.prev && on_i) |=> cold_o);
    a_r2_warm_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wcnt <= LEN);
    a_r4_cold_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ccnt <= LEN);
endmodule

// File: rtl/rdc_host.sv
module rdc_host #(
    parameter int HOST_DLY = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic any_glob_i,
    output logic held_o
);
    localparam int CW = $clog2(HOST_DLY + 1);
    localparam logic [CW-1:0] DLY = CW'(HOST_DLY);

    typedef struct packed {
        logic          held;
        logic [CW-1:0] cnt;
    } host_st_t;

    host_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (any_glob_i)            st_d.cnt = DLY;
        else if (st_q.cnt != '0)   st_d.cnt = st_q.cnt - CW'(1);
        st_d.held = any_glob_i || (st_q.cnt > CW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{held: 1'b1, cnt: DLY};
        else        st_q <= st_d;
    end

    assign held_o = st_q.held;

    a_r7_hold_while_req: assert property (@(posedge clk) disable iff (!rst_n)
        any_glob_i |=> held_o);
    a_r7_release_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(held_o) |-> $past(!any_glob_i));
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= DLY);
endmodule

// File: rtl/rst_dist_ctrl.sv
module rst_dist_ctrl
    import rdc_pkg::*;
#(
    parameter int NUM_DOM     = 4,
    parameter int PULSE_LEN   = 8,
    parameter int HOST_DLY    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               req_ext_warm,
    input  logic               req_emu_warm,
    input  logic               req_sw_warm,
    input  logic               req_sw_cold,
    input  logic               req_test,
    input  logic [NUM_DOM-1:0] dom_on,
    output logic               emu_trace_rst,
    output logic               emu_pin_mux_rst,
    output logic [NUM_DOM-1:0] dom_warm_rst,
    output logic [NUM_DOM-1:0] dom_cold_rst,
    output logic               rst_out
);
    typedef struct packed {
        logic glob_warm;
        logic glob_cold;
        logic trace;
        logic mux;
    } top_st_t;

    logic               por_rel;
    logic               por_act;
    req_t               req_raw;
    logic [REQ_W-1:0]   req_sync_bits;
    req_t               rs;
    logic [NUM_DOM-1:0] on_sync;
    logic               warm_src;
    logic               any_glob;
    top_st_t            st_d, st_q;

    rdc_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_por_sync (
        .clk(clk), .rst_n(por_n), .d_i(1'b1), .q_o(por_rel));
    assign por_act = !por_rel;

    assign req_raw = '{ext_warm: req_ext_warm, emu_warm: req_emu_warm,
                       sw_warm: req_sw_warm, sw_cold: req_sw_cold, tst: req_test};

    rdc_sync #(.W(REQ_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
        .clk(clk), .rst_n(por_n), .d_i(req_raw), .q_o(req_sync_bits));
    assign rs = req_t'(req_sync_bits);

    rdc_sync #(.W(NUM_DOM), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_dom_sync (
        .clk(clk), .rst_n(por_n), .d_i(dom_on), .q_o(on_sync));

    assign warm_src = rs.ext_warm || rs.emu_warm || rs.sw_warm;
    assign any_glob = por_act || warm_src || rs.sw_cold;

    always_comb begin
        st_d.glob_warm = warm_src;
        st_d.glob_cold = por_act || rs.sw_cold;
        st_d.trace     = por_act || rs.sw_cold || rs.tst;
        st_d.mux       = any_glob;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '{glob_warm: 1'b0, glob_cold: 1'b1, trace: 1'b1, mux: 1'b1};
        else        st_q <= st_d;
    end

    assign emu_trace_rst   = st_q.trace;
    assign emu_pin_mux_rst = st_q.mux;

    rdc_host #(.HOST_DLY(HOST_DLY)) u_host (
        .clk(clk), .rst_n(por_n), .any_glob_i(any_glob), .held_o(rst_out));

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
        rdc_dom #(.PULSE_LEN(PULSE_LEN)) u_dom (
            .clk        (clk),
            .rst_n      (por_n),
            .por_act_i  (por_act),
            .on_i       (on_sync[g]),
            .glob_warm_i(st_q.glob_warm),
            .glob_cold_i(st_q.glob_cold),
            .warm_o     (dom_warm_rst[g]),
            .cold_o     (dom_cold_rst[g]));
    end

    a_r5_warm_skips_trace: assert property (@(posedge clk) disable iff (!por_n)
        (warm_src && !rs.sw_cold && !rs.tst && !por_act) |=> !emu_trace_rst);
    a_r6_test_skips_mux: assert property (@(posedge clk) disable iff (!por_n)
        (rs.tst && !any_glob) |=> !emu_pin_mux_rst);
    a_r8_por_holds_all: assert property (@(posedge clk) disable iff (!por_n)
        por_act |-> (rst_out && emu_trace_rst && emu_pin_mux_rst && (&dom_cold_rst)));
    a_r1_warm_reaches_domains: assert property (@(posedge clk) disable iff (!por_n)
        warm_src |=> (&dom_warm_rst));
endmodule

// File: tb/rst_dist_ctrl_test.sv
module rst_dist_ctrl_test;
    localparam int ND = 4;
    localparam int PL = 8;
    localparam int HD = 16;

    logic          clk = 1'b0;
    logic          por_n;
    logic          r_ext, r_emu, r_sww, r_swc, r_tst;
    logic [ND-1:0] dom_on;
    logic          emu_trace_rst, emu_pin_mux_rst, rst_out;
    logic [ND-1:0] dom_warm_rst, dom_cold_rst;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rst_dist_ctrl #(.NUM_DOM(ND), .PULSE_LEN(PL), .HOST_DLY(HD), .SYNC_STAGES(2)) uut (
        .clk(clk), .por_n(por_n),
        .req_ext_warm(r_ext), .req_emu_warm(r_emu), .req_sw_warm(r_sww),
        .req_sw_cold(r_swc), .req_test(r_tst), .dom_on(dom_on),
        .emu_trace_rst(emu_trace_rst), .emu_pin_mux_rst(emu_pin_mux_rst),
        .dom_warm_rst(dom_warm_rst), .dom_cold_rst(dom_cold_rst), .rst_out(rst_out));

    // request bits {ext, emu, sw_warm, sw_cold, test}; expected {trace, mux, warm_all, cold_all, rst_out}
    localparam logic [9:0] VEC [7] = '{
        10'b10000_01101,
        10'b01000_01101,
        10'b00100_01101,
        10'b00010_11011,
        10'b00001_10000,
        10'b10001_11101,
        10'b00110_11111
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input logic [4:0] e, input string tag);
        logic [ND-1:0] ew, ec;
        ew = e[2] ? '1 : '0;
        ec = e[1] ? '1 : '0;
        check(emu_trace_rst == e[4], {tag, " R5 trace"}, emu_trace_rst, e[4]);
        check(emu_pin_mux_rst == e[3], {tag, " R6 mux"}, emu_pin_mux_rst, e[3]);
        check(dom_warm_rst == ew, {tag, " R1 R10 warm"}, dom_warm_rst, ew);
        check(dom_cold_rst == ec, {tag, " R3 R10 cold"}, dom_cold_rst, ec);
        check(rst_out == e[0], {tag, " R7 rst_out"}, rst_out, e[0]);
    endtask

    task automatic set_req(input logic [4:0] r);
        {r_ext, r_emu, r_sww, r_swc, r_tst} = r;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    initial begin
        int cw1, cw0, cc1, cc0, ro;
        por_n  = 1'b1;
        dom_on = '1;
        set_req(5'b0);
        #2 por_n = 1'b0;
        #6;
        // R8: asserted before any clock edge
        check_all(5'b11011, "R8 async por");
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        check_all(5'b11011, "R8 por release hold");
        repeat (HD + 10) @(negedge clk);
        check_all(5'b00000, "R8 idle after por");

        // table of request patterns
        foreach (VEC[i]) begin
            set_req(VEC[i][9:5]);
            repeat (5) @(negedge clk);
            check_all(VEC[i][4:0], $sformatf("vec%0d", i));
            set_req(5'b0);
            repeat (HD + 10) @(negedge clk);
            check_all(5'b00000, $sformatf("vec%0d idle", i));
        end

        // R9: latency of a synchronized request
        set_req(5'b00001);
        @(posedge clk);
        @(negedge clk);
        check(emu_trace_rst == 1'b0, "R9 too early", emu_trace_rst, 0);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(emu_trace_rst == 1'b1, "R9 third edge", emu_trace_rst, 1);
        set_req(5'b0);
        repeat (10) @(negedge clk);

        // R7: host release window
        set_req(5'b00100);
        repeat (4) @(negedge clk);
        set_req(5'b0);
        repeat (HD - 1) @(negedge clk);
        check(rst_out == 1'b1, "R7 still held", rst_out, 1);
        repeat (6) @(negedge clk);
        check(rst_out == 1'b0, "R7 released", rst_out, 0);
        repeat (4) @(negedge clk);

        // R2: domain 1 switches off
        cw1 = 0; cw0 = 0; cc1 = 0; ro = 0;
        dom_on[1] = 1'b0;
        for (int k = 0; k < PL + 8; k++) begin
            @(negedge clk);
            cw1 += dom_warm_rst[1];
            cw0 += dom_warm_rst[0];
            cc1 += dom_cold_rst[1];
            ro  += rst_out;
        end
        check(cw1 == PL, "R2 warm pulse width", cw1, PL);
        check(cw0 == 0, "R2 other domain quiet", cw0, 0);
        check(cc1 == 0 && ro == 0, "R2 no cold or rst_out", cc1 + ro, 0);

        // R4: domain 1 switches back on
        cw1 = 0; cc1 = 0; cc0 = 0;
        dom_on[1] = 1'b1;
        for (int k = 0; k < PL + 8; k++) begin
            @(negedge clk);
            cw1 += dom_warm_rst[1];
            cc1 += dom_cold_rst[1];
            cc0 += dom_cold_rst[0];
        end
        check(cc1 == PL, "R4 cold pulse width", cc1, PL);
        check(cc0 == 0, "R4 other domain quiet", cc0, 0);
        check(cw1 == 0, "R4 no warm", cw1, 0);

        finish_up();
    end
endmodule